// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the processor-side register port of a tile-based video processor. A CPU bus access anywhere in the range 0x2000 to 0x3FFF selects one of eight registers by the low three address bits, so the eight-byte window repeats across the whole range. The port holds the control and mask bytes, the vertical-blank flag, the sprite-memory pointer and a toggle that is shared by the two double-write registers (scroll and video address). It also keeps a 14-bit video memory pointer and a one-byte read-ahead buffer.

A write to the video-data register goes straight out on a write port to the external video memory. A read of that register is answered from the buffer, which is then refilled from memory at the pointer. The one exception is the palette region at the top of the address space, where the freshly fetched byte is returned at once. Either access then advances the pointer by 1 or by 32. Sprite-data writes go out on a separate sprite-memory write port and step the sprite pointer. A pulse from the display timing logic sets the vertical-blank flag. The block raises a one-cycle NMI request when that pulse arrives with NMI enabled, or when NMI becomes enabled while the flag is already set.

Top module: `vrp_top`

## Requirements
- R1: Only addresses 0x2000..0x3FFF (inclusive) reach the registers, with the register chosen by address bits [2:0]. The index map is 0 control, 1 mask, 2 status, 3 sprite pointer, 4 sprite data, 5 scroll, 6 video address and 7 video data. An access outside the range changes no state, drives no memory strobe and reads 0.
- R2: A status read (index 2) returns the vertical-blank flag in bit 7 and zeros in bits 6..0. The read clears both the flag and the shared write toggle, unless a vertical-blank pulse arrives in the same cycle, in which case the flag stays set.
- R3: Each scroll or video-address write flips the toggle. A video-address write with the toggle clear loads pointer bits [13:8] from data[5:0]. With the toggle set, it loads pointer bits [7:0] from data[7:0].
- R4: A video-data read (index 7) with the pointer below 0x3F00 returns the buffer. The read asserts the memory read strobe with the memory address equal to the pointer, and the buffer takes the memory byte at the clock edge.
- R5: A video-data read with the pointer at 0x3F00 or above returns the memory byte at the pointer in the same cycle. The buffer is still refilled with that byte.
- R6: Every video-data read or write advances the pointer by 1, or by 32 when control bit 2 is 1, modulo 0x4000. The pointer is always visible on the memory address output.
- R7: A video-data write asserts the memory write strobe in the access cycle, with the address equal to the pointer before the advance and the write data equal to the CPU data.
- R8: A sprite-pointer write (index 3) loads the pointer. A sprite-data write (index 4) asserts the sprite write strobe at the current pointer with the CPU data, then adds 1 modulo 256.
- R9: A vertical-blank pulse sets the flag. If control bit 7 is 1 after that cycle, including when a control write in the same cycle sets it, the NMI output is high for the next cycle.
- R10: A control write that changes bit 7 from 0 to 1 while the flag is set makes the NMI output high for the next cycle. A control write with bit 7 already 1 does not.
- R11: After reset every register, the pointer, the buffer, the toggle, the flag and the NMI output are 0.
- R12: The control and mask bytes are visible on their outputs from the cycle after the write. Reads of indices other than 2 and 7 return 0, as do idle cycles.
- R13: When write and read are both asserted, the access is a write and the read has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | CPU bus address |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | CPU read data, combinational during the access |
| vblankSet | input | 1 | Vertical-blank start pulse from display timing |
| nmiReq | output | 1 | One-cycle NMI request |
| ctrlOut | output | 8 | Control byte |
| maskOut | output | 8 | Mask byte |
| vmemAddr | output | 14 | Video memory address (the pointer) |
| vmemWrEn | output | 1 | Video memory write strobe |
| vmemWrData | output | 8 | Video memory write data |
| vmemRdEn | output | 1 | Video memory read strobe |
| vmemRdData | input | 8 | Video memory read data, combinational from vmemAddr |
| sprAddr | output | 8 | Sprite memory pointer |
| sprWrEn | output | 1 | Sprite memory write strobe |
| sprWrData | output | 8 | Sprite memory write data |

## Verification
The bench targets the one-read lag of the buffer and the palette bypass. A design that bypasses everywhere, or nowhere, returns the wrong byte on the first read after the address is set. It steps the pointer by 32 across 0x3FFF, where a missing modulo leaves the pointer out of range. It enables NMI while the vertical-blank flag is set, where a level-based NMI would fire again on a repeated enable write. It also reads status between the two halves of an address write, where a design that fails to clear the toggle loads the wrong half. Mirrored and out-of-range addresses, simultaneous read and write, and sprite pointer wrap at 0xFF are checked against a reference model on every clock.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_MASK    = 3'd1,
    REG_STATUS  = 3'd2,
    REG_SPRADDR = 3'd3,
    REG_SPRDATA = 3'd4,
    REG_SCROLL  = 3'd5,
    REG_VADDR   = 3'd6,
    REG_VDATA   = 3'd7
  } regIdx_e;

  localparam int INC_BIT = 2;
  localparam int NMI_BIT = 7;

  typedef struct packed {
    logic ctrlWr;
    logic maskWr;
    logic statusRd;
    logic sprAddrWr;
    logic sprDataWr;
    logic scrollWr;
    logic vaddrWr;
    logic vdataWr;
    logic vdataRd;
  } regStrb_t;
endpackage

// File: rtl/vrp_ctrl.sv
module vrp_ctrl
  import vrp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h2000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 16'h3FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              vblankSet,
  output regStrb_t          strb,
  output logic [DATA_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] maskReg,
  output logic              vblankFlag,
  output logic              writeToggle,
  output logic              nmiReq
);
  logic    inWin, accWr, accRd;
  regIdx_e idx;
  logic [DATA_W-1:0] ctrlNext;
  logic    nmiNext;

  assign inWin = (cpuAddr >= WIN_BASE) && (cpuAddr <= WIN_LAST);
  assign idx   = regIdx_e'(cpuAddr[2:0]);
  assign accWr = inWin && cpuWr;
  assign accRd = inWin && cpuRd && !cpuWr;

  always_comb begin
    strb           = '0;
    strb.ctrlWr    = accWr && (idx == REG_CTRL);
    strb.maskWr    = accWr && (idx == REG_MASK);
    strb.statusRd  = accRd && (idx == REG_STATUS);
    strb.sprAddrWr = accWr && (idx == REG_SPRADDR);
    strb.sprDataWr = accWr && (idx == REG_SPRDATA);
    strb.scrollWr  = accWr && (idx == REG_SCROLL);
    strb.vaddrWr   = accWr && (idx == REG_VADDR);
    strb.vdataWr   = accWr && (idx == REG_VDATA);
    strb.vdataRd   = accRd && (idx == REG_VDATA);
  end

  assign ctrlNext = strb.ctrlWr ? cpuWrData : ctrlReg;
  assign nmiNext  = (vblankSet && ctrlNext[NMI_BIT]) ||
                    (strb.ctrlWr && cpuWrData[NMI_BIT] && !ctrlReg[NMI_BIT] && vblankFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg     <= '0;
      maskReg     <= '0;
      vblankFlag  <= 1'b0;
      writeToggle <= 1'b0;
      nmiReq      <= 1'b0;
    end else begin
      ctrlReg <= ctrlNext;
      if (strb.maskWr) maskReg <= cpuWrData;
      if (vblankSet)          vblankFlag <= 1'b1;
      else if (strb.statusRd) vblankFlag <= 1'b0;
      if (strb.statusRd)                       writeToggle <= 1'b0;
      else if (strb.scrollWr || strb.vaddrWr)  writeToggle <= !writeToggle;
      nmiReq <= nmiNext;
    end
  end

  // R2
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRd && !vblankSet) |=> (!vblankFlag && !writeToggle));
  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.scrollWr || strb.vaddrWr) |=> (writeToggle != $past(writeToggle)));
  // R9
  vblank_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    vblankSet |=> vblankFlag);
  // R10
  nmi_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> $past(vblankSet || strb.ctrlWr));
endmodule

// File: rtl/vrp_datapath.sv
module vrp_datapath
  import vrp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W = 14,
  parameter int SPR_W = 8,
  parameter logic [PTR_W-1:0] PAL_START = 14'h3F00,
  parameter int WIDE_STEP = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              incWide,
  input  logic              writeToggle,
  input  logic              vblankFlag,
  input  logic [DATA_W-1:0] vmemRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [PTR_W-1:0]  vmemAddr,
  output logic              vmemWrEn,
  output logic [DATA_W-1:0] vmemWrData,
  output logic              vmemRdEn,
  output logic [SPR_W-1:0]  sprAddr,
  output logic              sprWrEn,
  output logic [DATA_W-1:0] sprWrData
);
  localparam int HI_W = PTR_W - DATA_W;

  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  step;
  logic [DATA_W-1:0] rdBuf;
  logic              inPalette;

  assign step      = incWide ? PTR_W'(WIDE_STEP) : PTR_W'(1);
  assign inPalette = (ptr >= PAL_START);

  assign vmemAddr   = ptr;
  assign vmemWrEn   = strb.vdataWr;
  assign vmemWrData = cpuWrData;
  assign vmemRdEn   = strb.vdataRd;
  assign sprWrEn    = strb.sprDataWr;
  assign sprWrData  = cpuWrData;

  always_comb begin
    cpuRdData = '0;
    if (strb.statusRd)     cpuRdData = {vblankFlag, {(DATA_W-1){1'b0}}};
    else if (strb.vdataRd) cpuRdData = inPalette ? vmemRdData : rdBuf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      rdBuf   <= '0;
      sprAddr <= '0;
    end else begin
      if (strb.vaddrWr) begin
        if (writeToggle) ptr <= {ptr[PTR_W-1:DATA_W], cpuWrData};
        else             ptr <= {cpuWrData[HI_W-1:0], ptr[DATA_W-1:0]};
      end else if (strb.vdataWr || strb.vdataRd) begin
        ptr <= ptr + step;
      end
      if (strb.vdataRd) rdBuf <= vmemRdData;
      if (strb.sprAddrWr)      sprAddr <= cpuWrData[SPR_W-1:0];
      else if (strb.sprDataWr) sprAddr <= sprAddr + SPR_W'(1);
    end
  end

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vdataWr || strb.vdataRd) |=> (vmemAddr == $past(vmemAddr) + $past(step)));
  // R8
  spr_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sprDataWr |=> (sprAddr == $past(sprAddr) + SPR_W'(1)));
  // R7
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({vmemWrEn, vmemRdEn, sprWrEn}));
endmodule

// File: rtl/vrp_top.sv
module vrp_top
  import vrp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PTR_W = 14,
  parameter int SPR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              vblankSet,
  output logic              nmiReq,
  output logic [DATA_W-1:0] ctrlOut,
  output logic [DATA_W-1:0] maskOut,
  output logic [PTR_W-1:0]  vmemAddr,
  output logic              vmemWrEn,
  output logic [DATA_W-1:0] vmemWrData,
  output logic              vmemRdEn,
  input  logic [DATA_W-1:0] vmemRdData,
  output logic [SPR_W-1:0]  sprAddr,
  output logic              sprWrEn,
  output logic [DATA_W-1:0] sprWrData
);
  regStrb_t strb;
  logic     vblankFlag, writeToggle;

  vrp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWrData(cpuWrData), .vblankSet(vblankSet), .strb(strb),
    .ctrlReg(ctrlOut), .maskReg(maskOut), .vblankFlag(vblankFlag),
    .writeToggle(writeToggle), .nmiReq(nmiReq)
  );

  vrp_datapath #(.DATA_W(DATA_W), .PTR_W(PTR_W), .SPR_W(SPR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuWrData(cpuWrData),
    .incWide(ctrlOut[INC_BIT]), .writeToggle(writeToggle), .vblankFlag(vblankFlag),
    .vmemRdData(vmemRdData), .cpuRdData(cpuRdData), .vmemAddr(vmemAddr),
    .vmemWrEn(vmemWrEn), .vmemWrData(vmemWrData), .vmemRdEn(vmemRdEn),
    .sprAddr(sprAddr), .sprWrEn(sprWrEn), .sprWrData(sprWrData)
  );
endmodule

// File: tb/vrp_top_tb_top.sv
module vrp_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuWr = 1'b0, cpuRd = 1'b0, vblankSet = 1'b0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData, ctrlOut, maskOut, vmemWrData, vmemRdData, sprAddr, sprWrData;
  logic        nmiReq, vmemWrEn, vmemRdEn, sprWrEn;
  logic [13:0] vmemAddr;

  int checks = 0;
  int fails = 0;

  // model state
  int mPtr = 0, mBuf = 0, mCtrl = 0, mMask = 0, mSpr = 0;
  bit mTog = 0, mVbl = 0, mNmi = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] vh(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b10};
  endfunction
  assign vmemRdData = vh(vmemAddr);

  vrp_top dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .vblankSet(vblankSet),
    .nmiReq(nmiReq), .ctrlOut(ctrlOut), .maskOut(maskOut), .vmemAddr(vmemAddr),
    .vmemWrEn(vmemWrEn), .vmemWrData(vmemWrData), .vmemRdEn(vmemRdEn),
    .vmemRdData(vmemRdData), .sprAddr(sprAddr), .sprWrEn(sprWrEn), .sprWrData(sprWrData)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input bit w, input bit r, input int a, input int d, input bit vbs);
    bit sel, wr, rd;
    int idx, expRd, stp, nCtrl;
    string rdTag;
    @(negedge clk);
    chk("R12", "ctrlOut", ctrlOut, mCtrl);
    chk("R12", "maskOut", maskOut, mMask);
    chk("R9/R10", "nmiReq", nmiReq, mNmi);
    chk("R6", "vmemAddr", vmemAddr, mPtr);
    chk("R8", "sprAddr", sprAddr, mSpr);
    cpuWr = w; cpuRd = r; cpuAddr = a[15:0]; cpuWrData = d[7:0]; vblankSet = vbs;
    #1;
    sel = (a >= 'h2000) && (a <= 'h3FFF);
    wr = w && sel;
    rd = r && !w && sel;
    idx = a & 7;
    expRd = 0;
    rdTag = sel ? (w && r ? "R13" : "R12") : "R1";
    if (rd && idx == 2) begin expRd = mVbl ? 'h80 : 0; rdTag = "R2"; end
    if (rd && idx == 7) begin
      if (mPtr >= 'h3F00) begin expRd = vh(mPtr[13:0]); rdTag = "R5"; end
      else begin expRd = mBuf; rdTag = "R4"; end
    end
    chk(rdTag, "cpuRdData", cpuRdData, expRd);
    chk(sel ? "R7" : "R1", "vmemWrEn", vmemWrEn, wr && idx == 7);
    chk(sel ? "R4" : "R1", "vmemRdEn", vmemRdEn, rd && idx == 7);
    chk(sel ? "R8" : "R1", "sprWrEn", sprWrEn, wr && idx == 4);
    if (wr && idx == 7) chk("R7", "vmemWrData", vmemWrData, d & 'hFF);
    if (wr && idx == 4) chk("R8", "sprWrData", sprWrData, d & 'hFF);
    // model next state
    stp = (mCtrl & 4) ? 32 : 1;
    nCtrl = (wr && idx == 0) ? (d & 'hFF) : mCtrl;
    mNmi = (vbs && (nCtrl & 'h80)) || (wr && idx == 0 && (d & 'h80) && !(mCtrl & 'h80) && mVbl);
    if (rd && idx == 7) mBuf = vh(mPtr[13:0]);
    if (wr && idx == 6) begin
      if (mTog) mPtr = (mPtr & 'h3F00) | (d & 'hFF);
      else      mPtr = ((d & 'h3F) << 8) | (mPtr & 'hFF);
    end
    if ((wr || rd) && idx == 7) mPtr = (mPtr + stp) % 'h4000;
    if (wr && idx == 3) mSpr = d & 'hFF;
    if (wr && idx == 4) mSpr = (mSpr + 1) % 256;
    if (wr && idx == 1) mMask = d & 'hFF;
    mCtrl = nCtrl;
    if (rd && idx == 2) mTog = 0;
    else if (wr && (idx == 5 || idx == 6)) mTog = !mTog;
    if (vbs) mVbl = 1;
    else if (rd && idx == 2) mVbl = 0;
  endtask

  task automatic wrR(input int a, input int d); doOp(1, 0, a, d, 0); endtask
  task automatic rdR(input int a); doOp(0, 1, a, 0, 0); endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "nmiReq", nmiReq, 0);
    chk("R11", "vmemAddr", vmemAddr, 0);
    chk("R11", "ctrlOut", ctrlOut, 0);
    chk("R11", "sprAddr", sprAddr, 0);
    rstN = 1'b1;
    doOp(0, 0, 0, 0, 0);
    // R3 address set, R4 buffered reads
    wrR('h2006, 'h21); wrR('h2006, 'h08);
    rdR('h2007); rdR('h2007); rdR('h3FFF);
    // R5 palette through a mirror
    wrR('h3FF6, 'h3F); wrR('h3FFE, 'h10); rdR('h2007); rdR('h2007);
    // R6 wide step with wrap
    wrR('h2000, 'h04); wrR('h2006, 'h3F); wrR('h2006, 'hF0);
    wrR('h2007, 'h5A); wrR('h2007, 'hA5); rdR('h2007);
    wrR('h2000, 'h00);
    // R1 outside window
    wrR('h4007, 'h11); wrR('h1FFF, 'h22); rdR('h4002); wrR('h1FF8, 'h80);
    // R2 status, toggle clear
    wrR('h2006, 'h12); rdR('h2002); wrR('h2006, 'h05); wrR('h2005, 'h00); wrR('h2005, 'h00);
    doOp(0, 0, 0, 0, 1); rdR('h2002); rdR('h2002);
    // R9 R10 nmi cases
    doOp(0, 0, 0, 0, 1); wrR('h2000, 'h80); wrR('h2000, 'h80); doOp(0, 0, 0, 0, 0);
    doOp(0, 0, 0, 0, 1); doOp(0, 0, 0, 0, 0);
    wrR('h2000, 'h00); doOp(1, 0, 'h2000, 'h80, 1); doOp(0, 0, 0, 0, 0);
    rdR('h2002); wrR('h2000, 'h00); wrR('h2000, 'h80); doOp(0, 1, 'h2002, 0, 1);
    // R8 sprite wrap
    wrR('h2003, 'hFE); wrR('h2004, 'h01); wrR('h2004, 'h02); wrR('h2004, 'h03);
    // R13 simultaneous access, R12 mask
    doOp(1, 1, 'h2007, 'h77, 0); doOp(1, 1, 'h2002, 'h00, 0); wrR('h2001, 'h1E);
    rdR('h2000); rdR('h2005);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int a;
      a = ($urandom % 10 == 0) ? ($urandom & 'hFFFF) : ('h2000 + ($urandom & 'h1FFF));
      doOp($urandom % 3 == 0, $urandom % 2 == 0, a, $urandom & 'hFF, $urandom % 12 == 0);
    end
    doOp(0, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule